// File: doc/BRIEF.md
# Accumulative Hash Padding Detector

This block sits beside a hash engine that works in accumulate mode, where one message arrives as a series of requests. It keeps a running byte count over all requests of the current message. For each request it decides whether the request already carries the message's own padding, which makes it the last one, and where that padding begins.

The decision is taken from the data, not from a list-end flag. The last eight bytes of a request are read as a big-endian bit count, which is turned into a byte count. That count is compared with the running total to find a candidate padding offset inside the request. The detector then fetches the byte at that offset through a byte read port. Only a byte value of 0x80 marks the request as final.

On a final request the hash datapath is told to keep only the bytes before the offset. The running total and the count of cached non-final segments are then cleared. The hash arithmetic itself lies outside this block.

Top module: `acc_pad_detector`

## Requirements
- R1: After reset `total_o` and `segs_o` are zero, `req_ready_o` is high, and `rd_en_o` and `res_valid_o` are low.
- R2: A request is taken when `req_valid_i` and `req_ready_o` are both high at a clock edge. From the next cycle `total_o` equals its old value plus `req_len_i` (modulo 2^TOT_W), and this happens before the padding check. While `req_ready_o` is low, `req_valid_i` has no effect on `total_o`.
- R3: `req_tail_i` holds the request's last eight bytes in memory order: bits [8k+7:8k] hold the byte at address `req_len_i`-8+k. These bytes form a big-endian 64-bit bit count, with the lowest address most significant. The byte count is that value shifted right by 3 and is reported on `res_msg_len_o`.
- R4: Let pad = total − byte count. If the byte count exceeds the updated total, or if pad is not in the range 1..`req_len_i`, no read is issued. In that case `res_valid_o` pulses two cycles after acceptance with `res_final_o`=0 and `res_pad_off_o`=`req_len_i`. This includes a zero-length request.
- R5: Otherwise `rd_en_o` pulses for exactly one cycle, two cycles after acceptance, with `rd_addr_o` = `req_len_i` − pad.
- R6: `res_final_o` is 1 exactly when the byte returned with `rd_valid_i` equals 0x80. `res_valid_o` is a one-cycle pulse, high in the cycle after `rd_valid_i` is seen.
- R7: `res_keep_len_o` equals the padding offset on a final result and `req_len_i` otherwise.
- R8: A final result clears `total_o` and `segs_o` in the cycle it is reported. A non-final result increments `segs_o`, which saturates at 2^SEG_W−1.
- R9: `clr_i` clears `total_o` and `segs_o` on the next edge and abandons any request in progress without a result. A later `rd_valid_i` has no effect.
- R10: `req_eol_i` has no effect on finality. Its value is returned on `res_eol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clears the running state and abandons a request in progress |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Detector is idle and takes a request |
| req_len_i | input | LEN_W | Request length in bytes |
| req_tail_i | input | 64 | Last eight request bytes, in memory order |
| req_eol_i | input | 1 | List-end flag of the request |
| rd_en_o | output | 1 | Byte read strobe, one cycle |
| rd_addr_o | output | LEN_W | Byte offset to read within the request |
| rd_data_i | input | 8 | Returned byte |
| rd_valid_i | input | 1 | Returned byte is valid |
| res_valid_o | output | 1 | Result pulse |
| res_final_o | output | 1 | Request holds the padding |
| res_pad_off_o | output | LEN_W | Padding offset, or request length when out of range |
| res_keep_len_o | output | LEN_W | Bytes to pass on as message data |
| res_msg_len_o | output | 61 | Decoded message length in bytes |
| res_eol_o | output | 1 | Echo of the list-end flag |
| total_o | output | TOT_W | Running byte total |
| segs_o | output | SEG_W | Cached non-final segment count |

## Verification
The bench targets the edges of the padding window. It uses a pad of zero, which would place the offset one byte past the request. It uses a pad equal to the whole length, which gives offset zero, and a zero-length request. A design with an off-by-one in the window would either read outside the request or miss a request made entirely of padding. A tail whose low three bits are set, and a list of bytes given in memory order, show whether the byte-order swap and the divide by eight are correct. A wrong swap or a wrong divide changes the reported length and the read address.

Further tests show whether the design mistakes a set list-end flag or a near-miss byte 0x81 for the final marker. They also check whether the total is updated before the compare: the wrong order would shift every offset. Other cases cover a clear issued while a read is pending, a request offered while busy, and read latencies of zero to three cycles. A design that got these wrong would leak a stale result, count a request twice, or report the result at the wrong cycle.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
    localparam int TAIL_BITS = 64;
    localparam int TAIL_BYTES = TAIL_BITS / 8;
    localparam logic [7:0] MARK_BYTE = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_WAIT = 2'd2
    } hpd_state_e;
endpackage

// File: rtl/hpd_tail_decode.sv
// Turns eight bytes given in memory order into a big-endian bit count,
// then into a byte count.
module hpd_tail_decode
    import hpd_pkg::*;
#(
    parameter int MSG_W = TAIL_BITS - 3
) (
    input  logic [TAIL_BITS-1:0] tail_i,
    output logic [MSG_W-1:0]     msg_bytes_o
);
    logic [TAIL_BITS-1:0] bits_be;

    // Lowest address becomes the most significant byte.
    for (genvar k = 0; k < TAIL_BYTES; k++) begin : g_swap
        assign bits_be[TAIL_BITS-1-8*k -: 8] = tail_i[8*k +: 8];
    end

    assign msg_bytes_o = bits_be[TAIL_BITS-1:3];
endmodule

// File: rtl/hpd_offset_calc.sv
// Computes the padding size and checks that the marker position falls
// inside the current request.
module hpd_offset_calc #(
    parameter int LEN_W = 28,
    parameter int TOT_W = 32,
    parameter int MSG_W = 61
) (
    input  logic [TOT_W-1:0] total_i,
    input  logic [MSG_W-1:0] msg_bytes_i,
    input  logic [LEN_W-1:0] req_len_i,
    output logic             inside_o,
    output logic [LEN_W-1:0] offset_o
);
    localparam int CMP_W = (MSG_W > TOT_W) ? MSG_W : TOT_W;

    logic [CMP_W-1:0] msg_x;
    logic [CMP_W-1:0] tot_x;
    logic [TOT_W-1:0] pad;
    logic             fits;

    always_comb begin
        msg_x = CMP_W'(msg_bytes_i);
        tot_x = CMP_W'(total_i);
        fits = (msg_x <= tot_x);
        pad = total_i - TOT_W'(msg_bytes_i);
        // Offset range is 0 .. len-1, so pad must be 1 .. len.
        inside_o = fits && (pad != '0) && (pad <= TOT_W'(req_len_i));
        offset_o = req_len_i - LEN_W'(pad);
    end
endmodule

// File: rtl/hpd_ledger.sv
// Running byte total and cached segment count.
module hpd_ledger #(
    parameter int LEN_W = 28,
    parameter int TOT_W = 32,
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en_i,
    input  logic [LEN_W-1:0] add_len_i,
    input  logic             wipe_i,
    input  logic             bump_i,
    output logic [TOT_W-1:0] total_o,
    output logic [SEG_W-1:0] segs_o
);
    typedef struct packed {
        logic [TOT_W-1:0] total;
        logic [SEG_W-1:0] segs;
    } led_t;

    led_t led_d, led_q;

    always_comb begin
        led_d = led_q;
        if (wipe_i) begin
            led_d.total = '0;
            led_d.segs = '0;
        end else begin
            if (add_en_i) begin
                led_d.total = led_q.total + TOT_W'(add_len_i);
            end
            if (bump_i && (led_q.segs != '1)) begin
                led_d.segs = led_q.segs + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q <= '0;
        end else begin
            led_q <= led_d;
        end
    end

    assign total_o = led_q.total;
    assign segs_o = led_q.segs;
endmodule

// File: rtl/acc_pad_detector.sv
module acc_pad_detector
    import hpd_pkg::*;
#(
    parameter int LEN_W = 28,
    parameter int TOT_W = 32,
    parameter int SEG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [LEN_W-1:0]       req_len_i,
    input  logic [TAIL_BITS-1:0]   req_tail_i,
    input  logic                   req_eol_i,
    output logic                   rd_en_o,
    output logic [LEN_W-1:0]       rd_addr_o,
    input  logic [7:0]             rd_data_i,
    input  logic                   rd_valid_i,
    output logic                   res_valid_o,
    output logic                   res_final_o,
    output logic [LEN_W-1:0]       res_pad_off_o,
    output logic [LEN_W-1:0]       res_keep_len_o,
    output logic [TAIL_BITS-4:0]   res_msg_len_o,
    output logic                   res_eol_o,
    output logic [TOT_W-1:0]       total_o,
    output logic [SEG_W-1:0]       segs_o
);
    localparam int MSG_W = TAIL_BITS - 3;

    typedef struct packed {
        hpd_state_e       state;
        logic [LEN_W-1:0] len;
        logic [MSG_W-1:0] msg;
        logic             eol;
        logic [LEN_W-1:0] off;
        logic             rd_en;
        logic             res_valid;
        logic             res_final;
        logic [LEN_W-1:0] res_off;
        logic [LEN_W-1:0] res_keep;
        logic [MSG_W-1:0] res_msg;
        logic             res_eol;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [MSG_W-1:0] dec_msg;
    logic             calc_inside;
    logic [LEN_W-1:0] calc_off;
    logic             add_en, wipe, bump, marker_hit;

    hpd_tail_decode #(.MSG_W(MSG_W)) u_dec (
        .tail_i      (req_tail_i),
        .msg_bytes_o (dec_msg)
    );

    hpd_offset_calc #(.LEN_W(LEN_W), .TOT_W(TOT_W), .MSG_W(MSG_W)) u_calc (
        .total_i     (total_o),
        .msg_bytes_i (ctl_q.msg),
        .req_len_i   (ctl_q.len),
        .inside_o    (calc_inside),
        .offset_o    (calc_off)
    );

    hpd_ledger #(.LEN_W(LEN_W), .TOT_W(TOT_W), .SEG_W(SEG_W)) u_led (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en_i  (add_en),
        .add_len_i (req_len_i),
        .wipe_i    (wipe),
        .bump_i    (bump),
        .total_o   (total_o),
        .segs_o    (segs_o)
    );

    assign marker_hit = (rd_data_i == MARK_BYTE);

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.rd_en = 1'b0;
        ctl_d.res_valid = 1'b0;
        add_en = 1'b0;
        wipe = 1'b0;
        bump = 1'b0;
        if (clr_i) begin
            ctl_d.state = ST_IDLE;
            wipe = 1'b1;
        end else begin
            case (ctl_q.state)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        ctl_d.len = req_len_i;
                        ctl_d.msg = dec_msg;
                        ctl_d.eol = req_eol_i;
                        add_en = 1'b1;
                        ctl_d.state = ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    ctl_d.res_msg = ctl_q.msg;
                    ctl_d.res_eol = ctl_q.eol;
                    if (calc_inside) begin
                        ctl_d.off = calc_off;
                        ctl_d.rd_en = 1'b1;
                        ctl_d.state = ST_WAIT;
                    end else begin
                        ctl_d.res_valid = 1'b1;
                        ctl_d.res_final = 1'b0;
                        ctl_d.res_off = ctl_q.len;
                        ctl_d.res_keep = ctl_q.len;
                        bump = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (rd_valid_i) begin
                        ctl_d.res_valid = 1'b1;
                        ctl_d.res_final = marker_hit;
                        ctl_d.res_off = ctl_q.off;
                        ctl_d.res_keep = marker_hit ? ctl_q.off : ctl_q.len;
                        wipe = marker_hit;
                        bump = !marker_hit;
                        ctl_d.state = ST_IDLE;
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o = (ctl_q.state == ST_IDLE);
    assign rd_en_o = ctl_q.rd_en;
    assign rd_addr_o = ctl_q.off;
    assign res_valid_o = ctl_q.res_valid;
    assign res_final_o = ctl_q.res_final;
    assign res_pad_off_o = ctl_q.res_off;
    assign res_keep_len_o = ctl_q.res_keep;
    assign res_msg_len_o = ctl_q.res_msg;
    assign res_eol_o = ctl_q.res_eol;
endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
    parameter int LEN_W = 28,
    parameter int TOT_W = 32,
    parameter int SEG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic [LEN_W-1:0] req_len_i,
    input logic             rd_en_o,
    input logic [7:0]       rd_data_i,
    input logic             rd_valid_i,
    input logic             res_valid_o,
    input logic             res_final_o,
    input logic [TOT_W-1:0] total_o,
    input logic [SEG_W-1:0] segs_o
);
    logic [TOT_W-1:0] len_ext;
    assign len_ext = TOT_W'(req_len_i);

    AST_ACCEPT_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o && req_valid_i && !clr_i) |=> (total_o == $past(total_o) + $past(len_ext))); // R2
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o); // R5
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !req_ready_o); // R5
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R6
    AST_FINAL_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_final_o) |-> $past(rd_valid_i && (rd_data_i == 8'h80))); // R6
    AST_FINAL_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_final_o) |-> (total_o == '0 && segs_o == '0)); // R8
    AST_CLEAR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (total_o == '0 && segs_o == '0 && !res_valid_o && req_ready_o)); // R9
endmodule

bind acc_pad_detector hpd_checker #(.LEN_W(LEN_W), .TOT_W(TOT_W), .SEG_W(SEG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_len_i   (req_len_i),
    .rd_en_o     (rd_en_o),
    .rd_data_i   (rd_data_i),
    .rd_valid_i  (rd_valid_i),
    .res_valid_o (res_valid_o),
    .res_final_o (res_final_o),
    .total_o     (total_o),
    .segs_o      (segs_o)
);

// File: tb/acc_pad_detector_test.sv
module acc_pad_detector_test;
    localparam int LEN_W = 28;
    localparam int TOT_W = 32;
    localparam int SEG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic req_valid_i = 1'b0;
    logic req_ready_o;
    logic [LEN_W-1:0] req_len_i = '0;
    logic [63:0] req_tail_i = '0;
    logic req_eol_i = 1'b0;
    logic rd_en_o;
    logic [LEN_W-1:0] rd_addr_o;
    logic [7:0] rd_data_i = '0;
    logic rd_valid_i = 1'b0;
    logic res_valid_o, res_final_o, res_eol_o;
    logic [LEN_W-1:0] res_pad_off_o, res_keep_len_o;
    logic [60:0] res_msg_len_o;
    logic [TOT_W-1:0] total_o;
    logic [SEG_W-1:0] segs_o;

    always #5 clk = ~clk;

    acc_pad_detector #(.LEN_W(LEN_W), .TOT_W(TOT_W), .SEG_W(SEG_W)) uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_len_i(req_len_i), .req_tail_i(req_tail_i), .req_eol_i(req_eol_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .rd_valid_i(rd_valid_i), .res_valid_o(res_valid_o), .res_final_o(res_final_o),
        .res_pad_off_o(res_pad_off_o), .res_keep_len_o(res_keep_len_o),
        .res_msg_len_o(res_msg_len_o), .res_eol_o(res_eol_o),
        .total_o(total_o), .segs_o(segs_o)
    );

    typedef struct packed {
        logic [27:0] len;
        logic [63:0] bits;
        logic        eol;
        logic [7:0]  mark;
        logic [3:0]  lat;
        logic        rd;
        logic [27:0] off;
        logic        fin;
    } vec_t;

    // len, big-endian bit count, eol, byte at offset, read latency,
    // read expected, expected offset, expected final
    localparam vec_t VECS [8] = '{
        '{28'd64, 64'd0,   1'b0, 8'h00, 4'd1, 1'b1, 28'd0,  1'b0},
        '{28'd64, 64'd800, 1'b1, 8'h80, 4'd0, 1'b1, 28'd36, 1'b1},
        '{28'd32, 64'h8000_0000_0000_0000, 1'b1, 8'h80, 4'd0, 1'b0, 28'd32, 1'b0},
        '{28'd16, 64'd384, 1'b0, 8'h80, 4'd0, 1'b0, 28'd16, 1'b0},
        '{28'd16, 64'd240, 1'b0, 8'h80, 4'd0, 1'b0, 28'd16, 1'b0},
        '{28'd20, 64'd560, 1'b1, 8'h81, 4'd2, 1'b1, 28'd6,  1'b0},
        '{28'd10, 64'd672, 1'b0, 8'h80, 4'd3, 1'b1, 28'd0,  1'b1},
        '{28'd8,  64'd47,  1'b0, 8'h80, 4'd0, 1'b1, 28'd5,  1'b1}
    };

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [TOT_W-1:0] m_total = '0;
    int m_segs = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] to_mem(input logic [63:0] be);
        logic [63:0] m;
        for (int k = 0; k < 8; k++) m[8*k +: 8] = be[63-8*k -: 8];
        return m;
    endfunction

    task automatic run_req(input logic [27:0] len, input logic [63:0] bits, input logic eol,
                           input logic [7:0] mark, input int lat, input bit exp_rd,
                           input logic [27:0] exp_off, input bit exp_fin);
        logic [28:0] keep;
        @(negedge clk);
        chk(req_ready_o == 1'b1, "R2", "ready before request", 64'(req_ready_o), 64'd1);
        req_valid_i = 1'b1; req_len_i = len; req_tail_i = to_mem(bits); req_eol_i = eol;
        @(negedge clk);
        req_valid_i = 1'b0;
        m_total = m_total + TOT_W'(len);
        chk(total_o == m_total, "R2", "total after accept", 64'(total_o), 64'(m_total));
        @(negedge clk);
        keep = {1'b0, len};
        if (exp_rd) begin
            chk(rd_en_o == 1'b1 && res_valid_o == 1'b0, "R5", "read strobe", 64'(rd_en_o), 64'd1);
            chk(rd_addr_o == exp_off, "R5", "read offset", 64'(rd_addr_o), 64'(exp_off));
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(rd_en_o == 1'b0 && res_valid_o == 1'b0, "R6", "quiet while waiting",
                    64'(res_valid_o), 64'd0);
            end
            rd_valid_i = 1'b1; rd_data_i = mark;
            @(negedge clk);
            rd_valid_i = 1'b0;
            chk(res_valid_o == 1'b1, "R6", "result after byte", 64'(res_valid_o), 64'd1);
            chk(res_final_o == exp_fin, "R6", "final flag", 64'(res_final_o), 64'(exp_fin));
            chk(res_pad_off_o == exp_off, "R6", "padding offset", 64'(res_pad_off_o), 64'(exp_off));
            if (exp_fin) keep = {1'b0, exp_off};
        end else begin
            chk(rd_en_o == 1'b0, "R4", "no read", 64'(rd_en_o), 64'd0);
            chk(res_valid_o == 1'b1 && res_final_o == 1'b0, "R4", "not final result",
                64'(res_final_o), 64'd0);
            chk(res_pad_off_o == len, "R4", "offset is length", 64'(res_pad_off_o), 64'(len));
        end
        chk(res_keep_len_o == keep[27:0], "R7", "keep length", 64'(res_keep_len_o), 64'(keep));
        chk(res_msg_len_o == bits[63:3], "R3", "message bytes", 64'(res_msg_len_o), 64'(bits[63:3]));
        chk(res_eol_o == eol, "R10", "list-end echo", 64'(res_eol_o), 64'(eol));
        if (exp_rd && exp_fin) begin
            m_total = '0; m_segs = 0;
        end else if (m_segs < 255) begin
            m_segs++;
        end
        chk(total_o == m_total, "R8", "total after result", 64'(total_o), 64'(m_total));
        chk(segs_o == SEG_W'(m_segs), "R8", "segments after result", 64'(segs_o), 64'(m_segs));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(total_o == '0, "R1", "total at reset", 64'(total_o), 64'd0);
        chk(segs_o == '0, "R1", "segments at reset", 64'(segs_o), 64'd0);
        chk(req_ready_o == 1'b1, "R1", "ready at reset", 64'(req_ready_o), 64'd1);
        chk(rd_en_o == 1'b0 && res_valid_o == 1'b0, "R1", "idle outputs", 64'(rd_en_o), 64'd0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            run_req(VECS[i].len, VECS[i].bits, VECS[i].eol, VECS[i].mark, int'(VECS[i].lat),
                    VECS[i].rd, VECS[i].off, VECS[i].fin);
        end

        // R2: request offered while busy is ignored
        @(negedge clk);
        req_valid_i = 1'b1; req_len_i = 28'd40; req_tail_i = to_mem(64'd80); req_eol_i = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b0;
        m_total = m_total + 32'd40;
        @(negedge clk);
        chk(rd_en_o == 1'b1 && rd_addr_o == 28'd10, "R5", "busy case read", 64'(rd_addr_o), 64'd10);
        req_valid_i = 1'b1; req_len_i = 28'd99;
        @(negedge clk);
        chk(req_ready_o == 1'b0, "R2", "not ready while waiting", 64'(req_ready_o), 64'd0);
        chk(total_o == m_total, "R2", "busy request ignored", 64'(total_o), 64'(m_total));
        @(negedge clk);
        req_valid_i = 1'b0;
        rd_valid_i = 1'b1; rd_data_i = 8'h00;
        @(negedge clk);
        rd_valid_i = 1'b0;
        m_segs++;
        chk(res_valid_o == 1'b1 && res_final_o == 1'b0, "R6", "zero byte not final",
            64'(res_final_o), 64'd0);
        @(negedge clk);
        chk(total_o == m_total && req_ready_o == 1'b1, "R2", "total still unchanged",
            64'(total_o), 64'(m_total));

        // R9: clear abandons a pending read
        req_valid_i = 1'b1; req_len_i = 28'd24; req_tail_i = to_mem(64'd400);
        @(negedge clk);
        req_valid_i = 1'b0;
        @(negedge clk);
        chk(rd_en_o == 1'b1 && rd_addr_o == 28'd10, "R5", "read before clear", 64'(rd_addr_o), 64'd10);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        m_total = '0; m_segs = 0;
        chk(total_o == '0 && segs_o == '0, "R9", "clear wipes state", 64'(total_o), 64'd0);
        chk(req_ready_o == 1'b1 && res_valid_o == 1'b0, "R9", "clear aborts", 64'(res_valid_o), 64'd0);
        rd_valid_i = 1'b1; rd_data_i = 8'h80;
        @(negedge clk);
        rd_valid_i = 1'b0;
        chk(res_valid_o == 1'b0, "R9", "late byte ignored", 64'(res_valid_o), 64'd0);

        // R4: zero-length request
        run_req(28'd0, 64'd0, 1'b0, 8'h80, 0, 1'b0, 28'd0, 1'b0);

        // R8: segment count saturation
        for (int n = 0; n < 256; n++) begin
            run_req(28'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'h80, 0, 1'b0, 28'd1, 1'b0);
        end
        chk(segs_o == 8'd255, "R8", "segment saturation", 64'(segs_o), 64'd255);

        finish_run();
    end
endmodule